// File: doc/BRIEF.md
# Dual-Bank Checkpointed Register File

This block holds the architectural registers as two physical copies (bank 0 and bank 1). It keeps a per-register selector (the mapping mask) that names the copy holding each register's latest value. Alongside it sits a per-register written-this-block mask. The first write to a register inside a basic block flips its selector and lands in the other copy. The value the register held when the previous block ended therefore stays untouched in the first copy. Later writes inside the same block reuse the new mapping.

When a basic block ends, the written mask clears and the current mapping is stored as the newest committed checkpoint. Checkpoints live in a ring of `MAX_BLOCKS + 1` slots. A rollback restores the mapping from the newest checkpoint in a single cycle. Every register written since that checkpoint then reads its value from the end of the previous block again.

A two-state control machine tracks whether the current block has written anything:
- `ST_CLEAN`: no write yet in the current block.
- `ST_DIRTY`: at least one write has been made.

Its transitions are:
- `ST_CLEAN` to `ST_DIRTY` on an accepted write with no block end in that cycle.
- `ST_DIRTY` to `ST_CLEAN` on block end or on rollback.
- All other cases hold the state.

Top module: `ckpt_regfile`

## Requirements
- R1: After reset every register reads 0 and the control machine is in `ST_CLEAN`.
- R2: A register written in one cycle reads back the written value from the next cycle on, on every read port.
- R3: A read port whose address equals the address being written in the same cycle (write enable high, rollback low) returns the write data in that cycle.
- R4: The first write to a register within a block flips that register's selector and writes the other copy, so the value committed at the previous block end survives and is returned after a rollback.
- R5: Further writes to the same register within the same block keep its selector unchanged; reads return the newest value, and a rollback still returns the value from the previous block end.
- R6: A block end (`blk_end` high, `rollback` low) commits the current contents, including a write made in the same cycle, as the point a later rollback returns to.
- R7: A rollback restores, in one cycle, every register written since the last commit to its committed value; registers not written since the commit are unaffected.
- R8: Rollback has priority: a write in the same cycle as a rollback is dropped, and a block end in the same cycle as a rollback does not commit.
- R9: In `ST_CLEAN` no register is marked written, so a rollback right after a block end changes no register value.
- R10: Several block ends in a row without writes leave all values unchanged, and a rollback always uses the newest of the `MAX_BLOCKS + 1` stored checkpoints.
- R11: During the cycle in which rollback is high, reads still return the values from before the rollback; the restored values appear from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | $clog2(NUM_REGS) | Register written |
| wr_data | input | DATA_W | Value written |
| blk_end | input | 1 | End of basic block: commit checkpoint |
| rollback | input | 1 | Restore mapping to newest checkpoint |
| rd_addr | input | NUM_RD*$clog2(NUM_REGS) | Read addresses, port p in slice p |
| rd_data | output | NUM_RD*DATA_W | Read data, port p in slice p |

## Verification
The assertions watch the mapping logic on every cycle:
- a first write flips exactly one selector bit, and a repeated write flips none;
- no cycle other than a rollback changes more than one selector bit;
- a rollback leaves the mapping equal to the newest checkpoint with nothing marked written;
- every register not written in the current block maps to the same copy as that checkpoint;
- the clean state implies an empty written mask.

Only the bench scenarios can show that the data comes back right. They cover the values returned after commits and rollbacks, the forwarding in the write cycle, the dropping of writes and commits under rollback, and the pre-rollback reads in the rollback cycle. All of these are checked against a two-array value model.

// File: rtl/ckpt_rf_pkg.sv
package ckpt_rf_pkg;
    typedef enum logic [0:0] {
        ST_CLEAN = 1'b0,
        ST_DIRTY = 1'b1
    } blk_state_e;
endpackage

// File: rtl/ckpt_rf_bank.sv
// One physical copy of the register file: single write port, NUM_RD async reads.
module ckpt_rf_bank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    parameter int ADDR_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NUM_RD*ADDR_W-1:0] raddr,
    output logic [NUM_RD*DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rdata[p*DATA_W +: DATA_W] = mem[raddr[p*ADDR_W +: ADDR_W]];
    end
endmodule

// File: rtl/ckpt_rf_map.sv
// Mapping control: selector mask, written mask, checkpoint ring, block FSM.
module ckpt_rf_map
    import ckpt_rf_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int MAX_BLOCKS = 3,
    parameter int ADDR_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic                blk_end,
    input  logic                rollback,
    output logic [NUM_REGS-1:0] sel_mask,
    output logic                wr_go,
    output logic                wr_bank
);
    localparam int RING  = MAX_BLOCKS + 1;
    localparam int PTR_W = (RING > 1) ? $clog2(RING) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(RING - 1);

    logic [NUM_REGS-1:0] map_q, dirty_q, map_wr, dirty_wr, ckpt_top;
    logic [NUM_REGS-1:0] ring_q [RING];
    logic [PTR_W-1:0]    ptr_q, ptr_nxt, top_idx;
    logic                wr_first;
    blk_state_e          fsm_q, fsm_d;

    // Next-state logic of the block FSM
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_CLEAN: if (!rollback && wr_en && !blk_end) fsm_d = ST_DIRTY;
            ST_DIRTY: if (rollback || blk_end)           fsm_d = ST_CLEAN;
            default:  fsm_d = ST_CLEAN;
        endcase
    end

    // State register of the block FSM
    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= ST_CLEAN;
        else        fsm_q <= fsm_d;
    end

    // Outputs and combinational mapping update
    always_comb begin
        wr_go    = wr_en & ~rollback;
        wr_first = wr_go & ~dirty_q[wr_addr];
        wr_bank  = dirty_q[wr_addr] ? map_q[wr_addr] : ~map_q[wr_addr];
        sel_mask = map_q;
        map_wr   = map_q;
        dirty_wr = dirty_q;
        if (wr_first) map_wr[wr_addr] = ~map_q[wr_addr];
        if (wr_go)    dirty_wr[wr_addr] = 1'b1;
        top_idx  = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
        ptr_nxt  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ckpt_top = ring_q[top_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q   <= '0;
            dirty_q <= '0;
            ptr_q   <= '0;
            for (int i = 0; i < RING; i++) ring_q[i] <= '0;
        end else if (rollback) begin
            map_q   <= ckpt_top;
            dirty_q <= '0;
        end else begin
            map_q   <= map_wr;
            dirty_q <= blk_end ? '0 : dirty_wr;
            if (blk_end) begin
                ring_q[ptr_q] <= map_wr;
                ptr_q         <= ptr_nxt;
            end
        end
    end

    AST_CLEAN_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q == ST_CLEAN |-> dirty_q == '0); // R9
    AST_FIRST_WRITE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && !dirty_q[wr_addr] |=> map_q[$past(wr_addr)] != $past(map_q[wr_addr])); // R4
    AST_REPEAT_NO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go && dirty_q[wr_addr] |=> map_q == $past(map_q)); // R5
    AST_ONE_FLIP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !rollback |=> $countones(map_q ^ $past(map_q)) <= 1); // R4
    AST_ROLLBACK_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> map_q == $past(ckpt_top) && dirty_q == '0); // R7
    AST_CLEAN_MATCHES_CKPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_q ^ ckpt_top) & ~dirty_q) == '0); // R7
    AST_BLKEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end && !rollback |=> dirty_q == '0 && fsm_q == ST_CLEAN); // R6
endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile #(
    parameter int NUM_REGS   = 16,
    parameter int DATA_W     = 32,
    parameter int MAX_BLOCKS = 3,
    parameter int NUM_RD     = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]          wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 blk_end,
    input  logic                                 rollback,
    input  logic [NUM_RD*$clog2(NUM_REGS)-1:0]   rd_addr,
    output logic [NUM_RD*DATA_W-1:0]             rd_data
);
    localparam int AW = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0]      sel_mask;
    logic                     wr_go, wr_bank;
    logic [NUM_RD*DATA_W-1:0] bank_rd [2];

    ckpt_rf_map #(
        .NUM_REGS(NUM_REGS), .MAX_BLOCKS(MAX_BLOCKS), .ADDR_W(AW)
    ) map_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .blk_end(blk_end), .rollback(rollback),
        .sel_mask(sel_mask), .wr_go(wr_go), .wr_bank(wr_bank)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        localparam logic BID = (b == 1);
        ckpt_rf_bank #(
            .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_RD), .ADDR_W(AW)
        ) bank_i (
            .clk(clk), .rst_n(rst_n), .we(wr_go && (wr_bank == BID)),
            .waddr(wr_addr), .wdata(wr_data),
            .raddr(rd_addr), .rdata(bank_rd[b])
        );
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rdmux
        logic [AW-1:0] ra;
        assign ra = rd_addr[p*AW +: AW];
        assign rd_data[p*DATA_W +: DATA_W] =
            (wr_go && wr_addr == ra) ? wr_data :
            (sel_mask[ra] ? bank_rd[1][p*DATA_W +: DATA_W]
                          : bank_rd[0][p*DATA_W +: DATA_W]);
    end
endmodule

// File: tb/ckpt_regfile_tb_top.sv
`timescale 1ns/1ps
module ckpt_regfile_tb_top;
    localparam int NR = 16, DW = 32, AW = 4, NP = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, blk_end = 1'b0, rollback = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NP*AW-1:0] rd_addr = '0;
    logic [NP*DW-1:0] rd_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [DW-1:0] cur [NR];
    logic [DW-1:0] cmt [NR];

    always #2 clk = ~clk;

    ckpt_regfile #(.NUM_REGS(NR), .DATA_W(DW), .MAX_BLOCKS(3), .NUM_RD(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .blk_end(blk_end), .rollback(rollback), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] ra, input logic we,
            input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rb);
        if (we && !rb && ra == a) return d;
        return cur[ra];
    endfunction

    // One cycle: drive after negedge, check reads, then clock and update model.
    task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
            input logic be, input logic rb, input logic [AW-1:0] r0, input logic [AW-1:0] r1,
            input string req);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; blk_end = be; rollback = rb;
        rd_addr = {r1, r0};
        #1;
        chk(req, rd_data[DW-1:0],    expect_rd(r0, we, a, d, rb));
        chk(req, rd_data[2*DW-1:DW], expect_rd(r1, we, a, d, rb));
        @(posedge clk);
        if (rb) begin
            for (int i = 0; i < NR; i++) cur[i] = cmt[i];
        end else begin
            if (we) cur[a] = d;
            if (be) for (int i = 0; i < NR; i++) cmt[i] = cur[i];
        end
    endtask

    task automatic idle_read(input logic [AW-1:0] r0, input logic [AW-1:0] r1, input string req);
        step(1'b0, '0, '0, 1'b0, 1'b0, r0, r1, req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NR; i++) begin cur[i] = '0; cmt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset contents
        for (int i = 0; i < NR; i += 2) idle_read(AW'(i), AW'(i + 1), "R1");

        // R2, R4, R5, R7: commit A, write B then C, roll back to A
        step(1'b1, 4'd3, 32'hAAAA_0003, 1'b0, 1'b0, 4'd3, 4'd4, "R3");
        step(1'b0, 4'd0, '0, 1'b1, 1'b0, 4'd3, 4'd4, "R2");
        step(1'b1, 4'd3, 32'hBBBB_0003, 1'b0, 1'b0, 4'd3, 4'd0, "R4");
        step(1'b1, 4'd3, 32'hCCCC_0003, 1'b0, 1'b0, 4'd0, 4'd3, "R5");
        idle_read(4'd3, 4'd4, "R5");
        // R11: rollback cycle still reads the newest value
        step(1'b0, 4'd0, '0, 1'b0, 1'b1, 4'd3, 4'd4, "R11");
        idle_read(4'd3, 4'd4, "R7");
        chk("R4", cur[3], 32'hAAAA_0003);

        // R6: write in the same cycle as block end is committed
        step(1'b1, 4'd5, 32'h5555_0001, 1'b1, 1'b0, 4'd5, 4'd3, "R6");
        step(1'b1, 4'd5, 32'h5555_0002, 1'b0, 1'b0, 4'd5, 4'd3, "R6");
        step(1'b0, 4'd0, '0, 1'b0, 1'b1, 4'd5, 4'd3, "R11");
        idle_read(4'd5, 4'd3, "R6");

        // R8: write under rollback dropped
        step(1'b1, 4'd6, 32'h6666_0006, 1'b0, 1'b1, 4'd6, 4'd5, "R8");
        idle_read(4'd6, 4'd5, "R8");
        // R8: block end under rollback does not commit
        step(1'b1, 4'd7, 32'h7777_0007, 1'b0, 1'b0, 4'd7, 4'd6, "R2");
        step(1'b0, 4'd0, '0, 1'b1, 1'b1, 4'd7, 4'd6, "R8");
        idle_read(4'd7, 4'd3, "R8");

        // R9: rollback right after a commit changes nothing
        step(1'b1, 4'd8, 32'h8888_0008, 1'b1, 1'b0, 4'd8, 4'd7, "R3");
        step(1'b0, 4'd0, '0, 1'b0, 1'b1, 4'd8, 4'd5, "R9");
        idle_read(4'd8, 4'd3, "R9");

        // R10: several empty commits, then rollback uses newest
        step(1'b1, 4'd9, 32'h9999_0001, 1'b1, 1'b0, 4'd9, 4'd8, "R10");
        repeat (6) step(1'b0, 4'd0, '0, 1'b1, 1'b0, 4'd9, 4'd8, "R10");
        step(1'b1, 4'd9, 32'h9999_0002, 1'b0, 1'b0, 4'd9, 4'd8, "R10");
        step(1'b0, 4'd0, '0, 1'b0, 1'b1, 4'd9, 4'd3, "R10");
        idle_read(4'd9, 4'd8, "R10");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            automatic logic we = ($urandom % 10) < 6;
            automatic logic be = ($urandom % 10) == 0;
            automatic logic rb = ($urandom % 20) == 0;
            automatic logic [AW-1:0] a  = AW'($urandom);
            automatic logic [AW-1:0] r0 = (($urandom % 4) == 0) ? a : AW'($urandom);
            automatic logic [AW-1:0] r1 = AW'($urandom);
            step(we, a, $urandom, be, rb, r0, r1, rb ? "R7" : ((we && r0 == a) ? "R3" : "R2"));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule